// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is an 8-bit parallel port that a CPU reaches over a small register bus. One set of pins can be used three ways. The first is plain I/O under a per-pin direction register. The second is a strobed input: a strobe line from the device captures the pins into a holding register. The third is a two-way handshake: a ready/strobe output line and the strobe input sequence a transfer in either direction with the device. A second, output-only byte register sits beside it. In the simple strobed mode, every write to that register pulses the ready/strobe line so that a receiver can latch the byte.

The strobe input comes from outside the clock domain. It passes through a synchroniser before its edges are detected. An edge of the selected polarity sets a status flag, and that flag can raise an interrupt. Software clears the flag in two steps: it reads the control register while the flag is set, then it accesses the holding register. The block runs on the same clock that times the CPU bus. Pulse lengths are counted in cycles of that clock.

Top module: `hsk_pport`

## Requirements
- R1: After reset the control register, the direction register and the status flag are 0, so every pin is an input (`pin_oe` = 0), `irq` is 0 and `strb_out` is 1 (the inactive level for active-low).
- R2: A read at address 1 returns, for each bit, the driver value when that bit's direction bit (address 3) is 1, and the live `pin_in` level when it is 0. A write at address 1 or address 2 loads the driver register, which appears on `pin_out`, and `pin_oe` equals the direction register.
- R3: An active strobe edge captures `pin_in` into the holding register, which is read at address 2, and sets the flag (control bit 7). The active edge is rising when control bit 1 is 1 and falling when it is 0. The opposite edge changes neither. The effect is visible after the third rising clock edge that follows the change on `stra_in`.
- R4: The flag clears when a read of address 0 that sees the flag at 1 is followed by a read or write of address 2. If an active edge arrives between those two accesses, the flag stays set.
- R5: `irq` is 1 exactly while the flag is 1 and control bit 6 (interrupt enable) is 1.
- R6: When control bit 4 is 0 (simple strobed mode), a write at address 4 loads `aux_out` and drives `strb_out` to its active level for exactly PULSE_CYC clock cycles. The active level is high when control bit 2 is 1 and low when it is 0.
- R7: When control bit 4 is 1 and control bit 3 is 0 (input handshake, interlocked when bit 0 is 0), `strb_out` goes active once the control register is written into this mode and again after each read of address 2. An active strobe edge returns it to inactive.
- R8: When control bits 4 and 3 are both 1 (output handshake), a write at address 2 drives the byte on `pin_out` and makes `strb_out` active. An active strobe edge makes it inactive and sets the flag, but it leaves the holding register unchanged. Writing the control register into this mode starts with `strb_out` inactive.
- R9: In either handshake mode with control bit 0 set to 1 (pulse mode), each event that would make the ready line active instead gives an active pulse of exactly PULSE_CYC cycles.
- R10: Control bits 6, 4, 3, 2, 1 and 0 are read back as written. Bit 5 reads as 0. Bit 7 is the read-only flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects occur on this cycle's edge) |
| bus_addr | input | 3 | Register address: 0 control, 1 pins, 2 holding, 3 direction, 4 auxiliary output |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from the address |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Driver register value |
| pin_oe | output | W | Per-pin output enable |
| aux_out | output | W | Auxiliary output byte |
| stra_in | input | 1 | Asynchronous strobe/acknowledge input |
| strb_out | output | 1 | Ready/strobe output |
| irq | output | 1 | Interrupt request |

## Verification
The capture path is driven with random pin bytes. The pins are changed right after each strobe, which shows whether the byte was taken on the active edge or later. The live-read path is driven with random mixes of direction, driver and pad values, which tells apart the bits taken from the driver and the bits taken from the pad. Every mode is run under all four combinations of strobe edge polarity and ready level, so an inverted polarity cannot pass unnoticed. Directed cases add a second edge inside the flag-clear sequence, and they count pulse widths cycle by cycle.

// File: rtl/hpp_pkg.sv
// Shared register addresses and control-bit positions of the handshake port.
// Assumes a byte-wide control register regardless of the data width.
package hpp_pkg;
    localparam int          ADDR_W   = 3;
    localparam logic [2:0]  A_CTRL   = 3'd0;
    localparam logic [2:0]  A_PIN    = 3'd1;
    localparam logic [2:0]  A_HOLD   = 3'd2;
    localparam logic [2:0]  A_DIR    = 3'd3;
    localparam logic [2:0]  A_AUX    = 3'd4;
    localparam int          CB_IE    = 6;
    localparam int          CB_HS    = 4;
    localparam int          CB_OUT   = 3;
    localparam int          CB_LVL   = 2;
    localparam int          CB_RISE  = 1;
    localparam int          CB_PULSE = 0;
    localparam logic [6:0]  CTRL_WMASK = 7'h5F;
endpackage

// File: rtl/hpp_edge_sync.sv
// Synchroniser plus edge detector for the strobe input.
// Assumes STAGES >= 2; emits a one-cycle pulse on the selected edge polarity.
module hpp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    // Shift the raw input through the synchroniser and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_in};
            last_q <= sh_q[STAGES-1];
        end
    end

    // Select the edge polarity that counts as active.
    always_comb begin
        edge_hit = rise_sel ? (sh_q[STAGES-1] & ~last_q)
                            : (~sh_q[STAGES-1] & last_q);
    end
endmodule

// File: rtl/hpp_flag_unit.sv
// Status flag with a two-step clear: a status read that sees the flag set
// arms the clear, and the next holding-register access performs it.
// An active edge always wins and cancels a pending arm.
module hpp_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic status_rd,
    input  logic data_acc,
    output logic flag_q
);
    logic arm_q;

    // Track the flag and the armed state of the clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (edge_hit)
                flag_q <= 1'b1;
            else if (arm_q && data_acc)
                flag_q <= 1'b0;

            if (edge_hit)
                arm_q <= 1'b0;
            else if (status_rd && flag_q)
                arm_q <= 1'b1;
            else if (data_acc)
                arm_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hpp_strobe_ctl.sv
// Ready/strobe output generator: an interlocked ready level plus a
// fixed-length pulse counter. The caller decides when to arm, disarm or pulse.
module hpp_strobe_ctl #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_mode,
    input  logic pulse_sel,
    input  logic act_high,
    input  logic arm,
    input  logic disarm,
    input  logic pulse_go,
    output logic rdy_q,
    output logic strb_act,
    output logic strb
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    logic [CW-1:0] cnt_q;

    // Interlocked ready level: a disarm beats an arm, and it drops outside handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdy_q <= 1'b0;
        else if (disarm)
            rdy_q <= 1'b0;
        else if (arm)
            rdy_q <= 1'b1;
        else if (!hs_mode)
            rdy_q <= 1'b0;
    end

    // Pulse counter: load on request, cut short by a disarm, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pulse_go && !disarm)
            cnt_q <= CW'(PULSE_CYC);
        else if (disarm)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Choose the level or the pulse source and apply the output polarity.
    always_comb begin
        strb_act = (hs_mode && !pulse_sel) ? rdy_q : (cnt_q != '0);
        strb     = act_high ? strb_act : ~strb_act;
    end
endmodule

// File: rtl/hsk_pport.sv
// Strobed handshake parallel port: register file, read mux and mode decode.
// Assumes W >= 8 and one bus access per cycle. Pins are sampled without
// synchronisation and must be stable when the strobe edge is detected.
module hsk_pport
    import hpp_pkg::*;
#(
    parameter int W           = 8,
    parameter int PULSE_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      aux_out,
    input  logic              stra_in,
    output logic              strb_out,
    output logic              irq
);
    logic [6:0]   ctrl_q;
    logic [W-1:0] drv_q, dir_q, hold_q, aux_q;
    logic         edge_hit, flag_q, rdy_q, strb_act;
    logic         wr_ctrl, wr_pin, wr_hold, wr_dir, wr_aux, rd_ctrl, acc_hold, rd_hold;
    logic         hs_mode, out_mode, new_in_hs, pulse_eff, arm, disarm, pulse_go;

    // Decode bus strobes per register.
    always_comb begin
        wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_pin   = bus_sel && bus_wr && (bus_addr == A_PIN);
        wr_hold  = bus_sel && bus_wr && (bus_addr == A_HOLD);
        wr_dir   = bus_sel && bus_wr && (bus_addr == A_DIR);
        wr_aux   = bus_sel && bus_wr && (bus_addr == A_AUX);
        rd_ctrl  = bus_sel && bus_rd && (bus_addr == A_CTRL);
        rd_hold  = bus_sel && bus_rd && (bus_addr == A_HOLD);
        acc_hold = rd_hold || wr_hold;
    end

    // Decode the mode and the ready/strobe events.
    always_comb begin
        hs_mode   = ctrl_q[CB_HS];
        out_mode  = ctrl_q[CB_OUT];
        new_in_hs = bus_wdata[CB_HS] && !bus_wdata[CB_OUT];
        pulse_eff = wr_ctrl ? bus_wdata[CB_PULSE] : ctrl_q[CB_PULSE];
        arm       = (wr_ctrl && new_in_hs)
                 || (hs_mode && !out_mode && rd_hold)
                 || (hs_mode && out_mode && wr_hold);
        disarm    = (hs_mode && edge_hit) || (wr_ctrl && !new_in_hs);
        pulse_go  = (!hs_mode && wr_aux) || (arm && pulse_eff);
    end

    // Control, direction, driver and auxiliary registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dir_q  <= '0;
            drv_q  <= '0;
            aux_q  <= '0;
        end else begin
            if (wr_ctrl)           ctrl_q <= bus_wdata[6:0] & CTRL_WMASK;
            if (wr_dir)            dir_q  <= bus_wdata;
            if (wr_pin || wr_hold) drv_q  <= bus_wdata;
            if (wr_aux)            aux_q  <= bus_wdata;
        end
    end

    // Holding register captures the pads on an active edge unless in output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (edge_hit && !(hs_mode && out_mode))
            hold_q <= pin_in;
    end

    hpp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(stra_in),
        .rise_sel(ctrl_q[CB_RISE]), .edge_hit(edge_hit)
    );

    hpp_flag_unit u_flag (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit),
        .status_rd(rd_ctrl), .data_acc(acc_hold), .flag_q(flag_q)
    );

    hpp_strobe_ctl #(.PULSE_CYC(PULSE_CYC)) u_strb (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .pulse_sel(ctrl_q[CB_PULSE]),
        .act_high(ctrl_q[CB_LVL]), .arm(arm), .disarm(disarm), .pulse_go(pulse_go),
        .rdy_q(rdy_q), .strb_act(strb_act), .strb(strb_out)
    );

    // Read mux: output pins return the driver value, input pins the pad level.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = W'({flag_q, ctrl_q});
            A_PIN:   bus_rdata = (dir_q & drv_q) | (~dir_q & pin_in);
            A_HOLD:  bus_rdata = hold_q;
            A_DIR:   bus_rdata = dir_q;
            A_AUX:   bus_rdata = aux_q;
            default: bus_rdata = '0;
        endcase
    end

    // Drive the pad-side and interrupt outputs.
    always_comb begin
        pin_out = drv_q;
        pin_oe  = dir_q;
        aux_out = aux_q;
        irq     = flag_q && ctrl_q[CB_IE];
    end
endmodule

// File: rtl/hsk_pport_chk.sv
// Temporal checks on the handshake port, attached to every instance by bind.
// Observes ports and the signals passed between the sub-blocks.
module hsk_pport_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [W-1:0] pin_out,
    input logic         irq,
    input logic         edge_hit,
    input logic         flag_q,
    input logic         rdy_q,
    input logic         strb_act,
    input logic         pulse_go,
    input logic         hs_mode
);
    // R3: a detected active edge always leaves the flag set on the next cycle.
    a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_q);

    // R4: the flag only rises as a result of an edge.
    a_r4_flag_rise_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(edge_hit));

    // R5: no interrupt without the flag.
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    // R6: an auxiliary write in simple mode starts an active pulse.
    a_r6_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_go && !hs_mode) |=> strb_act);

    // R7: an active edge in handshake mode drops the ready level.
    a_r7_edge_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && edge_hit) |=> !rdy_q);

    // R2: the driver value holds when no write occurs.
    a_r2_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(pin_out));
endmodule

bind hsk_pport hsk_pport_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .pin_out(pin_out), .irq(irq), .edge_hit(edge_hit), .flag_q(flag_q),
    .rdy_q(rdy_q), .strb_act(strb_act), .pulse_go(pulse_go), .hs_mode(hs_mode)
);

// File: tb/hsk_pport_bench.sv
module hsk_pport_bench;
    localparam int W = 8;
    localparam logic [7:0] C_IE = 8'h40, C_HS = 8'h10, C_OUT = 8'h08,
                           C_LVL = 8'h04, C_RISE = 8'h02, C_PULSE = 8'h01;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe, aux_out;
    logic         stra_in = 1'b0, strb_out, irq;
    int           n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    hsk_pport u_hsk_pport (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .aux_out(aux_out),
        .stra_in(stra_in), .strb_out(strb_out), .irq(irq)
    );

    function automatic logic [W-1:0] exp_live(logic [W-1:0] p, logic [W-1:0] d, logic [W-1:0] v);
        return (d & v) | (~d & p);
    endfunction

    function automatic logic exp_strb(logic active, logic lvl);
        return active ? lvl : ~lvl;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0; bus_rd = 0;
    endtask

    task automatic strobe(input logic v);
        stra_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] rv, p, d, v, held;
        logic [7:0]   base;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe", pin_oe, 0);
        check("R1 strb idle", strb_out, 1);
        check("R1 irq", irq, 0);
        brd(3'd0, rv); check("R1 ctrl", rv, 0);
        brd(3'd3, rv); check("R1 dir", rv, 0);

        // R2: random mixes of direction, driver and pad values
        for (int i = 0; i < 10; i++) begin
            d = W'($urandom); v = W'($urandom); p = W'($urandom);
            bwr(3'd3, d); bwr(3'd1, v); pin_in = p;
            brd(3'd1, rv);
            check("R2 live read", rv, exp_live(p, d, v));
            check("R2 pin_out", pin_out, v);
            check("R2 pin_oe", pin_oe, d);
        end
        bwr(3'd3, '0);

        // R10: control readback mask
        bwr(3'd0, 8'hFF); brd(3'd0, rv); check("R10 ctrl mask", rv, 8'h5F);
        bwr(3'd0, 8'h00);

        for (int pol = 0; pol < 2; pol++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                base = (pol[0] ? C_RISE : 8'h00) | (lvl[0] ? C_LVL : 8'h00);
                // simple strobed mode
                bwr(3'd0, base | C_IE);
                strobe(~pol[0]);
                brd(3'd0, rv); brd(3'd2, rv);
                check("R6 strb idle", strb_out, exp_strb(0, lvl[0]));
                for (int i = 0; i < 4; i++) begin
                    p = W'($urandom); pin_in = p;
                    strobe(pol[0]);
                    pin_in = ~p;
                    check("R5 irq set", irq, 1);
                    brd(3'd0, rv); check("R3 flag set", rv[7], 1);
                    brd(3'd2, rv); check("R3 captured byte", rv, p);
                    brd(3'd0, rv); check("R4 flag cleared", rv[7], 0);
                    check("R5 irq clear", irq, 0);
                    strobe(~pol[0]);
                    brd(3'd0, rv); check("R3 opposite edge no flag", rv[7], 0);
                    brd(3'd2, rv); check("R3 opposite edge no capture", rv, p);
                end
                // R4: an edge inside the clear sequence keeps the flag
                strobe(pol[0]);
                brd(3'd0, rv);
                strobe(~pol[0]); strobe(pol[0]);
                brd(3'd2, rv);
                brd(3'd0, rv); check("R4 flag kept by new edge", rv[7], 1);
                brd(3'd2, rv);
                brd(3'd0, rv); check("R4 flag cleared later", rv[7], 0);
                strobe(~pol[0]);
                // R6: auxiliary write pulse width
                v = W'($urandom);
                bwr(3'd4, v);
                check("R6 aux_out", aux_out, v);
                check("R6 pulse c1", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R6 pulse c2", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R6 pulse end", strb_out, exp_strb(0, lvl[0]));

                // R7: input handshake, interlocked
                bwr(3'd0, base | C_HS);
                check("R7 ready on entry", strb_out, exp_strb(1, lvl[0]));
                p = W'($urandom); pin_in = p;
                strobe(pol[0]);
                check("R7 ready drops on edge", strb_out, exp_strb(0, lvl[0]));
                brd(3'd0, rv); check("R7 flag", rv[7], 1);
                brd(3'd2, rv); check("R7 captured", rv, p);
                check("R7 ready after read", strb_out, exp_strb(1, lvl[0]));
                strobe(~pol[0]);
                check("R7 inactive edge ignored", strb_out, exp_strb(1, lvl[0]));
                held = p;

                // R9: input handshake, pulse mode
                bwr(3'd0, base | C_HS | C_PULSE);
                check("R9 in pulse c1", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R9 in pulse c2", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R9 in pulse end", strb_out, exp_strb(0, lvl[0]));

                // R8: output handshake, interlocked
                bwr(3'd3, 8'hFF);
                bwr(3'd0, base | C_HS | C_OUT);
                check("R8 idle on entry", strb_out, exp_strb(0, lvl[0]));
                v = W'($urandom);
                bwr(3'd2, v);
                check("R8 pins driven", pin_out, v);
                check("R8 ready asserted", strb_out, exp_strb(1, lvl[0]));
                pin_in = ~held;
                strobe(pol[0]);
                check("R8 ack drops ready", strb_out, exp_strb(0, lvl[0]));
                brd(3'd0, rv); check("R8 ack sets flag", rv[7], 1);
                brd(3'd2, rv); check("R8 no capture", rv, held);
                strobe(~pol[0]);

                // R9: output handshake, pulse mode
                bwr(3'd0, base | C_HS | C_OUT | C_PULSE);
                bwr(3'd2, ~v);
                check("R9 out pulse c1", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R9 out pulse c2", strb_out, exp_strb(1, lvl[0]));
                @(negedge clk); check("R9 out pulse end", strb_out, exp_strb(0, lvl[0]));

                bwr(3'd0, 8'h00); bwr(3'd3, 8'h00);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule